// File: doc/BRIEF.md
# Memory write protection controller

This block guards the nonvolatile array of a serial memory. The serial command decoder passes it one-cycle command pulses. A command is set latch, clear latch, write lock selection, or write. A write command carries the start address and the byte count. The block decides whether that write may go ahead. An accepted write is held pending while chip select stays low. It is committed on the rising edge of chip select. The block then times a fixed-length program cycle, and the array sees a one-cycle strobe with the address and the byte count.

Four things must line up for a write to be committed. The write enable latch must be set. The write-protect input must be high. The target page must lie outside the locked region. The byte count must fit in one page. The lock selection is kept in a 3-bit field and can cover nothing, the first page, the last page, any quarter of the array, or the lower half. The status byte shows, from bit 0 upward: busy, the latch, and the lock field in bits 4:2. Bits 7:5 read zero.

Top module: `wr_guard_ctrl`

## Requirements
- R1: After reset, status reads 0 (busy clear, latch clear, lock field 0 meaning nothing locked) and arr_we is low.
- R2: A command with cmd_op 1 sets the latch and cmd_op 2 clears it. Status bit 1 shows the change one clock after the command.
- R3: A write command (cmd_op 4) is refused while the latch is clear. A pending write is dropped if the latch is cleared before chip select rises.
- R4: A write command issued while wp_n is low is refused and leaves the latch unchanged.
- R5: If wp_n goes low while cs_n is still low after a write was accepted, the write is cancelled and no strobe follows.
- R6: If wp_n falls after the program cycle has started, the cycle runs for its full length.
- R7: The lock field codes are: 0 none, 1 page 0, 2 last page, 3 to 6 quarters 0 to 3 of the page range, and 7 the lower half. A write whose page is locked is refused and leaves the latch unchanged.
- R8: A lock write (cmd_op 3) takes effect only when the latch is set and wp_n is high. It loads cmd_lock into status bits 4:2 and clears the latch.
- R9: When cs_n rises with a write pending, arr_we pulses for one cycle after that edge. arr_addr and arr_len carry the write, and busy (status bit 0) stays high for CYCLE_CLKS cycles.
- R10: The latch clears on the same clock edge on which busy falls.
- R11: While busy is high, every command is ignored.
- R12: A write with a byte count of 0, or more than one page (2**PAGE_W bytes), is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; its rising edge commits a pending write |
| wp_n | input | 1 | Write-protect pin; low blocks writes |
| cmd_valid | input | 1 | One-cycle command pulse |
| cmd_op | input | 3 | Command code (1 set latch, 2 clear latch, 3 lock write, 4 write) |
| cmd_addr | input | ADDR_W | Start byte address of a write |
| cmd_len | input | PAGE_W+1 | Byte count of a write |
| cmd_lock | input | 3 | New lock field for a lock write |
| arr_we | output | 1 | One-cycle strobe that starts programming the array |
| arr_addr | output | ADDR_W | Address of the committed write |
| arr_len | output | PAGE_W+1 | Byte count of the committed write |
| status | output | 8 | {3'b0, lock field, latch, busy} |

## Verification
The latch and the lock field change on the first clock edge after a command pulse. The bench drives every input on the falling edge and reads status on the next falling edge. The commit strobe and the rising busy flag appear on the first edge that sees cs_n high. The bench raises chip select and samples arr_we exactly one falling edge later. Busy lasts CYCLE_CLKS cycles, so the bench counts its high falling-edge samples from the strobe sample onward and expects exactly that number.

// File: rtl/wgc_pkg.sv
// Shared command and lock codes for the write protection controller.
// Assumes the decoder presents commands as 3-bit codes.
package wgc_pkg;
    localparam logic [2:0] OP_NOP     = 3'd0;
    localparam logic [2:0] OP_SET_WEL = 3'd1;
    localparam logic [2:0] OP_CLR_WEL = 3'd2;
    localparam logic [2:0] OP_WR_LOCK = 3'd3;
    localparam logic [2:0] OP_WRITE   = 3'd4;

    localparam logic [2:0] LK_NONE  = 3'd0;
    localparam logic [2:0] LK_FIRST = 3'd1;
    localparam logic [2:0] LK_LAST  = 3'd2;
    localparam logic [2:0] LK_HALF  = 3'd7;
endpackage

// File: rtl/wgc_lock_map.sv
// Decides whether a page falls inside the locked region.
// Assumes at least four pages (PG_W >= 2); every region is page aligned.
module wgc_lock_map
    import wgc_pkg::*;
#(
    parameter int PG_W = 6
) (
    input  logic [2:0]      lock_sel,
    input  logic [PG_W-1:0] page,
    output logic            locked
);
    // Compare the page against the region picked by lock_sel.
    always_comb begin
        case (lock_sel)
            LK_NONE:  locked = 1'b0;
            LK_FIRST: locked = (page == '0);
            LK_LAST:  locked = (page == '1);
            LK_HALF:  locked = !page[PG_W-1];
            default:  locked = (page[PG_W-1 -: 2] == 2'(lock_sel - 3'd3));
        endcase
    end
endmodule

// File: rtl/wgc_cycle_timer.sv
// Self-timed program cycle: busy for CYCLE_CLKS clocks after start.
// Assumes start is never raised while busy is high.
module wgc_cycle_timer #(
    parameter int CYCLE_CLKS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

    logic [CNT_W-1:0] cnt;

    assign done = busy && (cnt == '0);

    // Load the count on start, count down, and drop busy on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(CYCLE_CLKS - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wr_guard_ctrl.sv
// Write protection controller. It keeps the write enable latch and the
// lock field, and qualifies write commands against the latch, the protect
// pin, the lock region and the byte count. An accepted write is held until
// chip select rises, and it is cancelled if protect falls before then.
// Assumes command pulses last one cycle and arrive while cs_n is low.
module wr_guard_ctrl
    import wgc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_W     = 4,
    parameter int CYCLE_CLKS = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [PAGE_W:0]   cmd_len,
    input  logic [2:0]        cmd_lock,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [PAGE_W:0]   arr_len,
    output logic [7:0]        status
);
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int LEN_W      = PAGE_W + 1;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic              wel, pend, cs_q, busy, done, page_locked;
    logic [2:0]        lock_q;
    logic [ADDR_W-1:0] pend_addr;
    logic [LEN_W-1:0]  pend_len;
    logic              take, len_ok, wr_ok, lock_ok, start, cancel;

    wgc_lock_map #(.PG_W(PG_W)) u_map (
        .lock_sel (lock_q),
        .page     (cmd_addr[ADDR_W-1:PAGE_W]),
        .locked   (page_locked)
    );

    wgc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    // Qualify the incoming command and the commit and cancel events.
    always_comb begin
        take    = cmd_valid && !busy;
        len_ok  = (cmd_len != '0) && (cmd_len <= LEN_W'(PAGE_BYTES));
        wr_ok   = take && (cmd_op == OP_WRITE) && wel && wp_n && !page_locked && len_ok;
        lock_ok = take && (cmd_op == OP_WR_LOCK) && wel && wp_n;
        start   = cs_n && !cs_q && pend && wel;
        cancel  = pend && !cs_n && !wp_n;
    end

    // Write enable latch: set and clear commands, cleared by a lock write and at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (done || lock_ok)
            wel <= 1'b0;
        else if (take && cmd_op == OP_SET_WEL)
            wel <= 1'b1;
        else if (take && cmd_op == OP_CLR_WEL)
            wel <= 1'b0;
    end

    // Lock field, loaded by a qualified lock write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= LK_NONE;
        else if (lock_ok)
            lock_q <= cmd_lock;
    end

    // Pending write: held until commit, cancellation or loss of the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_addr <= '0;
            pend_len  <= '0;
        end else if (start || cancel || (cs_n && !cs_q) || !wel) begin
            pend <= 1'b0;
        end else if (wr_ok) begin
            pend      <= 1'b1;
            pend_addr <= cmd_addr;
            pend_len  <= cmd_len;
        end
    end

    // Chip select history, used to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_q <= 1'b1;
        else
            cs_q <= cs_n;
    end

    // Array strobe and the write it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we   <= 1'b0;
            arr_addr <= '0;
            arr_len  <= '0;
        end else begin
            arr_we <= start;
            if (start) begin
                arr_addr <= pend_addr;
                arr_len  <= pend_len;
            end
        end
    end

    assign status = {3'b000, lock_q, wel, busy};
endmodule

// File: rtl/wr_guard_ctrl_chk.sv
// Temporal checks on the controller ports, bound into every instance.
module wr_guard_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        status
);
    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);
    // R9
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> status[0]);
    // R10
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);
    // R3
    wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(status[1]));
    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !$past(status[0]));
    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !arr_we) |-> $stable(arr_addr));
endmodule

bind wr_guard_ctrl wr_guard_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .status   (status)
);

// File: tb/tb_wr_guard_ctrl.sv
module tb_wr_guard_ctrl;
    localparam int AW  = 10;
    localparam int PW  = 4;
    localparam int CYC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [PW:0]   cmd_len = '0;
    logic [2:0]    cmd_lock = 3'd0;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [PW:0]   arr_len;
    logic [7:0]    status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    wr_guard_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .CYCLE_CLKS(CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_lock(cmd_lock), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_len(arr_len), .status(status)
    );

    always #2 clk = ~clk;

    // {lock code, page, expected strobe}
    localparam logic [9:0] VEC [0:16] = '{
        {3'd0, 6'd0,  1'b1}, {3'd1, 6'd0,  1'b0}, {3'd1, 6'd1,  1'b1},
        {3'd2, 6'd63, 1'b0}, {3'd2, 6'd62, 1'b1}, {3'd3, 6'd15, 1'b0},
        {3'd3, 6'd16, 1'b1}, {3'd4, 6'd16, 1'b0}, {3'd4, 6'd31, 1'b0},
        {3'd4, 6'd32, 1'b1}, {3'd5, 6'd32, 1'b0}, {3'd5, 6'd48, 1'b1},
        {3'd6, 6'd48, 1'b0}, {3'd6, 6'd47, 1'b1}, {3'd7, 6'd31, 1'b0},
        {3'd7, 6'd32, 1'b1}, {3'd6, 6'd63, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [PW:0] n, input logic [2:0] lk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_len = n; cmd_lock = lk;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        @(negedge clk);
    endtask

    // Write with chip select framing; returns the strobe seen after cs rises.
    task automatic wr(input logic [AW-1:0] a, input logic [PW:0] n, output logic we);
        cs_n = 1'b0;
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = a; cmd_len = n;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cs_n = 1'b1;
        @(negedge clk);
        we = arr_we;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (status[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic we;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 status", status, 0);
        chk("R1 strobe", arr_we, 0);

        // R2
        cmd(3'd1, '0, '0, '0);
        chk("R2 set", status[1], 1);
        cmd(3'd2, '0, '0, '0);
        chk("R2 clear", status[1], 0);

        // R3: no latch, then latch lost before commit
        wr(10'h050, 5'd2, we);
        chk("R3 no latch", we, 0);
        cmd(3'd1, '0, '0, '0);
        cs_n = 1'b0;
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 10'h050; cmd_len = 5'd2;
        @(negedge clk);
        cmd_op = 3'd2; cmd_addr = '0;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cs_n = 1'b1;
        @(negedge clk);
        chk("R3 latch lost", arr_we, 0);

        // R9 / R10: normal commit
        cmd(3'd1, '0, '0, '0);
        wr(10'h123, 5'd5, we);
        chk("R9 strobe", we, 1);
        chk("R9 addr", arr_addr, 10'h123);
        chk("R9 len", arr_len, 5);
        busy_len(n);
        chk("R9 busy length", n, CYC);
        chk("R10 latch cleared", status[1], 0);

        // R12: byte count bounds
        cmd(3'd1, '0, '0, '0);
        wr(10'h200, 5'd0, we);
        chk("R12 zero count", we, 0);
        wr(10'h200, 5'd17, we);
        chk("R12 over page", we, 0);
        wr(10'h200, 5'd16, we);
        chk("R12 full page", we, 1);
        busy_len(n);

        // R4: protect low refuses, latch kept
        cmd(3'd1, '0, '0, '0);
        wp_n = 1'b0;
        wr(10'h010, 5'd1, we);
        chk("R4 refused", we, 0);
        chk("R4 latch kept", status[1], 1);
        wp_n = 1'b1;

        // R5: protect falls while cs low after acceptance
        cs_n = 1'b0;
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 10'h010; cmd_len = 5'd1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; wp_n = 1'b0;
        @(negedge clk);
        wp_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        chk("R5 cancelled", arr_we, 0);
        chk("R5 latch kept", status[1], 1);

        // R6 / R11: protect falls and commands arrive during the cycle
        wr(10'h030, 5'd3, we);
        chk("R6 strobe", we, 1);
        wp_n = 1'b0;
        @(negedge clk);
        wp_n = 1'b1;
        cmd(3'd2, '0, '0, '0);
        chk("R11 clear ignored", status[1], 1);
        cmd(3'd3, '0, '0, 3'd7);
        chk("R11 lock ignored", status[4:2], 0);
        cs_n = 1'b0;
        cmd(3'd4, 10'h040, 5'd1, '0);
        cs_n = 1'b1;
        @(negedge clk);
        n = 0;
        while (status[0] && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R6 full length", n + 8, CYC);
        cs_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        chk("R11 write ignored", arr_we, 0);

        // R8: lock write qualification
        cmd(3'd3, '0, '0, 3'd5);
        chk("R8 no latch", status[4:2], 0);
        cmd(3'd1, '0, '0, '0);
        wp_n = 1'b0;
        cmd(3'd3, '0, '0, 3'd5);
        chk("R8 protect low", status[4:2], 0);
        wp_n = 1'b1;
        cmd(3'd3, '0, '0, 3'd5);
        chk("R8 loaded", status[4:2], 5);
        chk("R8 latch cleared", status[1], 0);

        // R7: lock region table
        for (int i = 0; i < 17; i++) begin
            cmd(3'd1, '0, '0, '0);
            cmd(3'd3, '0, '0, VEC[i][9:7]);
            cmd(3'd1, '0, '0, '0);
            wr({VEC[i][6:1], 4'd3}, 5'd4, we);
            chk("R7 region", we, VEC[i][0]);
            if (we) begin
                busy_len(n);
            end else begin
                chk("R7 latch kept", status[1], 1);
                cmd(3'd2, '0, '0, '0);
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule